// File: doc/BRIEF.md
# Receive FIFO interrupt wrapper

This block sits between a serial byte deserializer and a host bus. Each received character arrives as one byte on a write port. The byte is stored in a 256-entry first-in first-out buffer. The host sees the oldest byte on a show-ahead read port and pops it with a read request. A fill-count output tells the host exactly how many bytes it may burst-read.

An interrupt tells host driver code to drain the buffer. It is raised for either of two reasons. The first is that the fill level reaches a programmable threshold. The second is that the buffer holds data but no new byte has arrived for a programmable number of character times. One character time is ten bit periods of a programmable baud divisor. The second condition means that a short trailing message is delivered promptly, even when it never comes near the threshold.

The interrupt is held until the host acknowledges it. A byte written while the buffer is full is dropped and sets a sticky overflow flag, which the host clears.

Top module: `rx_fifo_irq`

## Requirements
- R1: After reset the fill count is 0, and `irq` and `overflow` are low. The threshold resets to 192, the idle count to 4 character times and the baud divisor to 1302.
- R2: Bytes leave in the order they were accepted. `rdData` shows the oldest byte, and `rdReq` pops it when the buffer is non-empty. `fillCount` gives the number of stored bytes, from 0 to 256. A read request while the buffer is empty has no effect.
- R3: A write while the buffer holds 256 bytes is dropped and leaves the count unchanged. It sets `overflow`, which stays high until `ovfClr` is pulsed.
- R4: When `fillCount` is at or above the threshold and the level source is armed, `irq` rises one clock after the count reaches that value.
- R5: The idle timer counts clocks. It raises `irq` exactly divisor×10×idleCount clocks after the last accepted write, provided the buffer stays non-empty. It fires once per gap, and an idle count of 0 disables it.
- R6: Once high, `irq` stays high until `irqAck` is pulsed, and it drops on the clock after the acknowledge.
- R7: After the level source has fired, it re-arms only when the count drops below the threshold or a new byte is accepted. Acknowledging while the count stays at or above the threshold does not re-raise `irq`.
- R8: The idle timer restarts on every accepted write and is held at zero while the buffer is empty. An empty buffer never raises an idle interrupt.
- R9: A configuration write with `cfgWe` high loads one setting, chosen by `cfgSel`. A value of 0 loads the threshold from `cfgData[8:0]`. A value of 1 loads the idle count from `cfgData[7:0]`. A value of 2 loads the baud divisor from `cfgData[15:0]`. A value of 3 loads nothing. New settings take effect on the next character-time calculation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | Byte from the deserializer is valid |
| wrData | input | 8 | Received byte |
| rdReq | input | 1 | Pop the oldest byte |
| rdData | output | 8 | Oldest stored byte (show-ahead) |
| fillCount | output | 9 | Number of stored bytes |
| overflow | output | 1 | Sticky dropped-byte flag |
| ovfClr | input | 1 | Clear the overflow flag |
| irq | output | 1 | Drain interrupt |
| irqAck | input | 1 | Interrupt acknowledge |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Configuration setting select |
| cfgData | input | 16 | Configuration value |

## Verification
The hardest situations to reach are the exact clock on which the idle timeout fires and the level source staying quiet after an acknowledge while the buffer is still above threshold. At the default divisor, a gap lasts tens of thousands of clocks. The stimulus therefore reprograms the divisor to 2 or 3 and the idle count to 1 or 2, which shrinks a gap to 30 or 40 clocks. The bench then samples `irq` one clock before and on the predicted clock, including after a second write that restarts the gap. For re-arming, a small threshold of 4 lets the bench acknowledge, hold, add one byte and drain below the threshold within a few cycles.

// File: rtl/rxirq_pkg.sv
package rxirq_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
  } fifoStrobe_t;
endpackage

// File: rtl/rxirq_datapath.sv
module rxirq_datapath
  import rxirq_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int DW = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoStrobe_t   stb,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic [CW-1:0] fillCount
);
  logic [DW-1:0] store [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (stb.push) store[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
    end else begin
      if (stb.push) wrPtr <= nextPtr(wrPtr);
      if (stb.pop)  rdPtr <= nextPtr(rdPtr);
      case ({stb.push, stb.pop})
        2'b10:   fillCount <= fillCount + 1'b1;
        2'b01:   fillCount <= fillCount - 1'b1;
        default: fillCount <= fillCount;
      endcase
    end
  end

  assign rdData = store[rdPtr];

  // R2
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CW'(DEPTH));

  // R2
  fill_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.push && !stb.pop) |=> fillCount == $past(fillCount) + 1'b1);
endmodule

// File: rtl/rxirq_control.sv
module rxirq_control
  import rxirq_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int CFGW = 16,
  parameter int DEF_THRESH = 192,
  parameter int DEF_IDLE = 4,
  parameter int DEF_DIV = 1302,
  localparam int CW = $clog2(DEPTH) + 1,
  localparam int IW = 8,
  localparam int CLW = CFGW + 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrValid,
  input  logic            rdReq,
  input  logic [CW-1:0]   fillCount,
  input  logic            cfgWe,
  input  logic [1:0]      cfgSel,
  input  logic [CFGW-1:0] cfgData,
  input  logic            irqAck,
  input  logic            ovfClr,
  output fifoStrobe_t     stb,
  output logic            irq,
  output logic            overflow
);
  logic [CW-1:0]   threshReg;
  logic [IW-1:0]   idleReg;
  logic [CFGW-1:0] divReg;
  logic [CLW-1:0]  cycCnt, charLen;
  logic [IW-1:0]   charCnt;
  logic full, empty, push, counting, lastCyc;
  logic idleHit, levelHit, lvlArmed, lvlFire, fire;

  assign full  = fillCount == CW'(DEPTH);
  assign empty = fillCount == '0;
  assign push  = wrValid && !full;
  assign stb.push = push;
  assign stb.pop  = rdReq && !empty;

  // Configuration settings
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      threshReg <= CW'(DEF_THRESH);
      idleReg   <= IW'(DEF_IDLE);
      divReg    <= CFGW'(DEF_DIV);
    end else if (cfgWe) begin
      case (cfgSel)
        2'd0:    threshReg <= cfgData[CW-1:0];
        2'd1:    idleReg   <= cfgData[IW-1:0];
        2'd2:    divReg    <= cfgData;
        default: ;
      endcase
    end
  end

  // Idle gap timer in character times
  assign charLen  = CLW'(divReg) * CLW'(10);
  assign lastCyc  = cycCnt == charLen - 1'b1;
  assign counting = !empty && (charCnt < idleReg);
  assign idleHit  = counting && !push && lastCyc && (charCnt == idleReg - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycCnt  <= '0;
      charCnt <= '0;
    end else if (push || empty) begin
      cycCnt  <= '0;
      charCnt <= '0;
    end else if (counting) begin
      if (lastCyc) begin
        cycCnt  <= '0;
        charCnt <= charCnt + 1'b1;
      end else begin
        cycCnt <= cycCnt + 1'b1;
      end
    end
  end

  // Interrupt and overflow
  assign levelHit = fillCount >= threshReg;
  assign lvlFire  = levelHit && lvlArmed;
  assign fire     = lvlFire || idleHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irq      <= 1'b0;
      lvlArmed <= 1'b1;
      overflow <= 1'b0;
    end else begin
      irq <= fire || (irq && !irqAck);
      if (lvlFire) lvlArmed <= 1'b0;
      else if (!levelHit || push) lvlArmed <= 1'b1;
      overflow <= (wrValid && full) || (overflow && !ovfClr);
    end
  end

  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !irqAck) |=> irq);

  // R6
  irq_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !fire) |=> !irq);

  // R3
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !ovfClr) |=> overflow);

  // R8
  timer_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    empty |=> (charCnt == '0 && cycCnt == '0));
endmodule

// File: rtl/rx_fifo_irq.sv
module rx_fifo_irq
  import rxirq_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int CFGW = 16,
  parameter int DEF_THRESH = 192,
  parameter int DEF_IDLE = 4,
  parameter int DEF_DIV = 1302
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrValid,
  input  logic [7:0]               wrData,
  input  logic                     rdReq,
  output logic [7:0]               rdData,
  output logic [$clog2(DEPTH):0]   fillCount,
  output logic                     overflow,
  input  logic                     ovfClr,
  output logic                     irq,
  input  logic                     irqAck,
  input  logic                     cfgWe,
  input  logic [1:0]               cfgSel,
  input  logic [CFGW-1:0]          cfgData
);
  fifoStrobe_t stb;

  rxirq_control #(
    .DEPTH(DEPTH), .CFGW(CFGW), .DEF_THRESH(DEF_THRESH),
    .DEF_IDLE(DEF_IDLE), .DEF_DIV(DEF_DIV)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .rdReq(rdReq),
    .fillCount(fillCount), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgData(cfgData), .irqAck(irqAck), .ovfClr(ovfClr),
    .stb(stb), .irq(irq), .overflow(overflow)
  );

  rxirq_datapath #(.DEPTH(DEPTH), .DW(8)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .rdData(rdData), .fillCount(fillCount)
  );
endmodule

// File: tb/sim_rx_fifo_irq.sv
module sim_rx_fifo_irq;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // writes, reads, expected fill count
  localparam int VEC [NVEC][3] = '{'{3,0,3}, '{0,1,2}, '{5,2,5}, '{1,0,6}, '{0,6,0}, '{0,2,0}};

  logic clk = 1'b0, rstN = 1'b0;
  logic wrValid = 1'b0, rdReq = 1'b0, ovfClr = 1'b0, irqAck = 1'b0, cfgWe = 1'b0;
  logic [7:0] wrData = '0;
  logic [1:0] cfgSel = '0;
  logic [15:0] cfgData = '0;
  logic [7:0] rdData;
  logic [8:0] fillCount;
  logic overflow, irq;

  int checks = 0, errors = 0;
  logic [7:0] model[$];
  logic [7:0] seqVal = 8'd1;
  bit done = 0;

  rx_fifo_irq u0 (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData), .rdReq(rdReq),
    .rdData(rdData), .fillCount(fillCount), .overflow(overflow), .ovfClr(ovfClr),
    .irq(irq), .irqAck(irqAck), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeByte();
    wrValid = 1'b1;
    wrData = seqVal;
    if (model.size() < 256) model.push_back(seqVal);
    seqVal++;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic readByte(input string req);
    if (model.size() > 0) begin
      chk(req, int'(rdData), int'(model[0]));
      void'(model.pop_front());
    end
    rdReq = 1'b1;
    @(negedge clk);
    rdReq = 1'b0;
  endtask

  task automatic drain();
    while (model.size() > 0) readByte("R2 order");
  endtask

  task automatic ack();
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
  endtask

  task automatic cfg(input logic [1:0] sel, input int val);
    cfgWe = 1'b1;
    cfgSel = sel;
    cfgData = 16'(val);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
    // R1 reset state
    chk("R1 count", int'(fillCount), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 overflow", int'(overflow), 0);

    // R1 default threshold 192, R4 level interrupt
    for (int i = 0; i < 191; i++) writeByte();
    waitCyc(1);
    chk("R1 below default threshold", int'(irq), 0);
    writeByte();
    chk("R4 count at threshold", int'(fillCount), 192);
    waitCyc(1);
    chk("R1 default threshold irq", int'(irq), 1);
    ack();
    chk("R6 ack clears", int'(irq), 0);
    drain();
    chk("R2 drained", int'(fillCount), 0);

    // R9 configuration: threshold out of reach, idle disabled
    cfg(2'd0, 511);
    cfg(2'd1, 0);
    cfg(2'd3, 5);

    // R2 vector table
    for (int i = 0; i < NVEC; i++) begin
      for (int w = 0; w < VEC[i][0]; w++) writeByte();
      for (int r = 0; r < VEC[i][1]; r++) readByte("R2 order");
      chk("R2 table count", int'(fillCount), VEC[i][2]);
    end
    chk("R9 sel3 no threshold change", int'(irq), 0);

    // R3 overflow
    for (int i = 0; i < 256; i++) writeByte();
    chk("R3 full count", int'(fillCount), 256);
    chk("R3 no overflow yet", int'(overflow), 0);
    writeByte();
    chk("R3 dropped count", int'(fillCount), 256);
    chk("R3 overflow set", int'(overflow), 1);
    waitCyc(5);
    chk("R3 overflow sticky", int'(overflow), 1);
    drain();
    ovfClr = 1'b1;
    @(negedge clk);
    ovfClr = 1'b0;
    chk("R3 overflow cleared", int'(overflow), 0);

    // R4 / R7 level source with threshold 4
    cfg(2'd0, 4);
    for (int i = 0; i < 3; i++) writeByte();
    waitCyc(1);
    chk("R4 below threshold", int'(irq), 0);
    writeByte();
    chk("R4 not yet", int'(irq), 0);
    waitCyc(1);
    chk("R4 level irq", int'(irq), 1);
    waitCyc(3);
    chk("R6 held", int'(irq), 1);
    ack();
    chk("R6 dropped after ack", int'(irq), 0);
    waitCyc(5);
    chk("R7 no refire above threshold", int'(irq), 0);
    writeByte();
    waitCyc(1);
    chk("R7 new byte refires", int'(irq), 1);
    ack();
    readByte("R2 order");
    readByte("R2 order");
    waitCyc(1);
    chk("R7 quiet below threshold", int'(irq), 0);
    writeByte();
    waitCyc(1);
    chk("R7 rearm after drain", int'(irq), 1);
    ack();
    drain();
    waitCyc(1);
    chk("R7 idle after drain", int'(irq), 0);

    // R5 idle gap: divisor 2, 2 chars = 40 clocks
    cfg(2'd0, 511);
    cfg(2'd2, 2);
    cfg(2'd1, 2);
    writeByte();
    waitCyc(39);
    chk("R5 before gap end", int'(irq), 0);
    waitCyc(1);
    chk("R5 idle irq", int'(irq), 1);
    ack();
    waitCyc(100);
    chk("R5 once per gap", int'(irq), 0);
    drain();

    // R8 empty holds timer, write restarts it
    waitCyc(100);
    chk("R8 empty no irq", int'(irq), 0);
    writeByte();
    waitCyc(25);
    writeByte();
    waitCyc(39);
    chk("R8 restart before end", int'(irq), 0);
    waitCyc(1);
    chk("R8 restart irq", int'(irq), 1);
    ack();
    drain();

    // R9 divisor 3, 1 char = 30 clocks
    cfg(2'd2, 3);
    cfg(2'd1, 1);
    writeByte();
    waitCyc(29);
    chk("R9 before new gap end", int'(irq), 0);
    waitCyc(1);
    chk("R9 new settings irq", int'(irq), 1);
    ack();
    drain();

    done = 1;
    summary();
    $finish;
  end
endmodule